// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block turns one whole register or EEPROM access into the string of bus-level commands that a separate bit engine carries out. Three kinds of request are taken: a probe, which checks whether a chip answers its address; a write, which sends a register address and a run of data bytes; and a read, which sets the chip's address pointer and then returns a run of bytes. Each request carries a 7-bit chip address, a register address of zero to four bytes with its byte count, and a data length. Write bytes are pulled from a byte stream and read bytes are pushed into another. Both streams use valid/ready handshakes.

Commands go to the bit engine one at a time over a valid/ready handshake. The engine answers each command with a one-cycle response that carries the acknowledge bit of a written byte, or the byte it has read. When the access ends, a one-cycle completion pulse gives an error flag and the number of data bytes a write saw refused. Two build options shape the bus traffic. One chooses how a read turns from its addressing phase to its data phase. The other folds high register-address bits into the chip address, for memories that hold extra address bits in the chip-address slots.

Top module: `i2c_xact_seq`

## Requirements
- R1: After reset, and after a one-cycle `init_req` while idle, the block issues exactly one RECOVER command (code 0) before it accepts a request, and `req_ready` stays low until that command has had its response.
- R2: A probe (op 0, or op 3) issues START (code 1), WRITE (code 3) of `{chip,0}`, then STOP (code 2). It completes with `done_err` 0 when the address byte is acknowledged and 1 when it is refused.
- R3: A write (op 1) issues START, WRITE `{chip,0}`, one WRITE per register-address byte with the most significant byte first, one WRITE per data byte taken from the write stream in order, then STOP.
- R4: A refused chip-address byte, in either the addressing or the read phase, or a refused register-address byte ends the access at once with STOP and `done_err` 1. No further byte is sent.
- R5: In a write, a refused data byte does not stop the transfer. `done_nacks` reports how many data bytes were refused and `done_err` stays 0.
- R6: A read (op 2) with a nonzero address count and nonzero length runs START, WRITE `{chip,0}` and the address bytes. It then issues START alone when `REP_START` is 1, or STOP followed by START when it is 0, and after that WRITE `{chip,1}`.
- R7: A read with an address count of 0 and a nonzero length issues START and then WRITE `{chip,1}` directly.
- R8: The read phase issues one READ (code 4) per byte. `cmd_nack` is 1 only on the last READ. The bytes come out on the read stream in the order they were read, and STOP follows.
- R9: When `OVF_MASK` is nonzero, the chip address sent is `chip | ((addr >> 8*alen) & OVF_MASK)`. The address-byte count is unchanged.
- R10: A write or read of length 0 sends START, WRITE `{chip,0}` and the address bytes, then STOP, and completes without error.
- R11: `done` is a single-cycle pulse after the final STOP's response. `req_ready` is high only while idle. A held command or read byte stays stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Requests a bus recovery when idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 0 probe, 1 write, 2 read, 3 probe |
| req_chip | input | 7 | Chip address |
| req_addr | input | 8*ABYTES_MAX | Register address, right aligned |
| req_alen | input | clog2(ABYTES_MAX+1) | Number of register-address bytes |
| req_len | input | clog2(LEN_MAX+1) | Number of data bytes |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Command to bit engine present |
| cmd_ready | input | 1 | Bit engine takes command |
| cmd_code | output | 3 | 0 RECOVER, 1 START, 2 STOP, 3 WRITE, 4 READ |
| cmd_byte | output | 8 | Byte for WRITE, else 0 |
| cmd_nack | output | 1 | For READ: refuse the byte |
| rsp_valid | input | 1 | Bit engine finished the last command |
| rsp_nack | input | 1 | Written byte was refused |
| rsp_byte | input | 8 | Byte read |
| done | output | 1 | Access complete |
| done_err | output | 1 | Access aborted or probe unanswered |
| done_nacks | output | clog2(LEN_MAX+1) | Refused data bytes of a write |

## Verification
The hardest case to reach from the ports is a refusal in the middle of an access: the chip acknowledges its address and then refuses a later register-address byte, or refuses only some of the data bytes. The stimulus reaches it with a bit-engine model that refuses write commands by their position inside the access, under a per-access mask. This makes it possible to abort after a register byte, or to refuse the first and third data bytes, and then compare the complete logged command list. Two copies of the block, one for each turnaround option, run every access side by side, and each copy's command list is compared with its own expected list.

// File: rtl/i2c_xact_seq_pkg.sv
package i2c_xact_seq_pkg;

   typedef enum logic [2:0] {
      CMD_RECOVER = 3'd0,
      CMD_START   = 3'd1,
      CMD_STOP    = 3'd2,
      CMD_WRITE   = 3'd3,
      CMD_READ    = 3'd4
   } cmd_e;

   typedef enum logic [1:0] {
      OP_PROBE = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      S_RECOV, S_IDLE, S_START, S_CHIPW, S_ADDR, S_TURN, S_START2,
      S_CHIPR, S_WDATA, S_RDATA, S_RDOUT, S_STOP, S_DONE
   } st_e;

endpackage

// File: rtl/i2c_xact_seq_chipfold.sv
module i2c_xact_seq_chipfold #(
   parameter int         AW       = 32,
   parameter int         ALW      = 3,
   parameter logic [6:0] OVF_MASK = 7'h00
) (
   input  logic [6:0]     chip,
   input  logic [AW-1:0]  addr,
   input  logic [ALW-1:0] alen,
   output logic [6:0]     chip_out
);
   localparam int EW = AW + 8;

   generate
      if (OVF_MASK == 7'h00) begin : g_plain
         logic unused_ok;
         assign unused_ok = ^{addr, alen};
         assign chip_out  = chip;
      end else begin : g_fold
         logic [EW-1:0] ext;
         logic [EW-1:0] hi;
         assign ext      = {8'h00, addr};
         assign hi       = ext >> {alen, 3'b000};
         assign chip_out = chip | (hi[6:0] & OVF_MASK);
      end
   endgenerate
endmodule

// File: rtl/i2c_xact_seq_bytepick.sv
module i2c_xact_seq_bytepick #(
   parameter int ABYTES_MAX = 4,
   parameter int AW         = 32,
   parameter int ALW        = 3
) (
   input  logic [AW-1:0]  addr,
   input  logic [ALW-1:0] alen,
   input  logic [ALW-1:0] idx,
   output logic [7:0]     abyte
);
   logic [7:0]     lanes [ABYTES_MAX];
   logic [ALW-1:0] sel;

   generate
      for (genvar g = 0; g < ABYTES_MAX; g++) begin : g_lane
         assign lanes[g] = addr[8*g +: 8];
      end
   endgenerate

   // most significant address byte goes out first
   assign sel = alen - idx - ALW'(1);

   always_comb begin
      abyte = 8'h00;
      for (int k = 0; k < ABYTES_MAX; k++)
         if (sel == ALW'(k)) abyte = lanes[k];
   end
endmodule

// File: rtl/i2c_xact_seq_fsm.sv
module i2c_xact_seq_fsm
   import i2c_xact_seq_pkg::*;
#(
   parameter int AW        = 32,
   parameter int ALW       = 3,
   parameter int LW        = 9,
   parameter bit REP_START = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           init_req,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [1:0]     req_op,
   input  logic [6:0]     chip_in,
   input  logic [AW-1:0]  req_addr,
   input  logic [ALW-1:0] req_alen,
   input  logic [LW-1:0]  req_len,
   output logic [AW-1:0]  addr_q,
   output logic [ALW-1:0] alen_q,
   output logic [ALW-1:0] idx_q,
   input  logic [7:0]     abyte,
   input  logic           wr_valid,
   output logic           wr_ready,
   input  logic [7:0]     wr_data,
   output logic           rd_valid,
   input  logic           rd_ready,
   output logic [7:0]     rd_data,
   output logic           cmd_valid,
   input  logic           cmd_ready,
   output logic [2:0]     cmd_code,
   output logic [7:0]     cmd_byte,
   output logic           cmd_nack,
   input  logic           rsp_valid,
   input  logic           rsp_nack,
   input  logic [7:0]     rsp_byte,
   output logic           done,
   output logic           done_err,
   output logic [LW-1:0]  done_nacks
);
   st_e           st;
   st_e           after_addr;
   logic          wait_q;
   op_e           op_q;
   logic [6:0]    chip_q;
   logic [LW-1:0] len_q;
   logic [LW-1:0] cnt_q;
   logic [LW-1:0] nacks_q;
   logic          err_q;
   logic [7:0]    rbyte_q;
   logic          last_byte;

   assign last_byte = (cnt_q == len_q - LW'(1));

   always_comb begin
      if (len_q == '0)            after_addr = S_STOP;
      else if (op_q == OP_WRITE)  after_addr = S_WDATA;
      else if (REP_START)         after_addr = S_START2;
      else                        after_addr = S_TURN;
   end

   always_comb begin
      cmd_valid = 1'b0;
      cmd_code  = CMD_STOP;
      cmd_byte  = 8'h00;
      cmd_nack  = 1'b0;
      wr_ready  = 1'b0;
      unique case (st)
         S_RECOV:          begin cmd_valid = !wait_q; cmd_code = CMD_RECOVER; end
         S_START, S_START2:begin cmd_valid = !wait_q; cmd_code = CMD_START;   end
         S_TURN, S_STOP:   begin cmd_valid = !wait_q; cmd_code = CMD_STOP;    end
         S_CHIPW: begin cmd_valid = !wait_q; cmd_code = CMD_WRITE; cmd_byte = {chip_q, 1'b0}; end
         S_CHIPR: begin cmd_valid = !wait_q; cmd_code = CMD_WRITE; cmd_byte = {chip_q, 1'b1}; end
         S_ADDR:  begin cmd_valid = !wait_q; cmd_code = CMD_WRITE; cmd_byte = abyte;          end
         S_WDATA: begin
            cmd_valid = !wait_q && wr_valid;
            cmd_code  = CMD_WRITE;
            cmd_byte  = wr_data;
            wr_ready  = !wait_q && cmd_ready;
         end
         S_RDATA: begin cmd_valid = !wait_q; cmd_code = CMD_READ; cmd_nack = last_byte; end
         default: ;
      endcase
   end

   assign req_ready  = (st == S_IDLE) && !init_req;
   assign rd_valid   = (st == S_RDOUT);
   assign rd_data    = rbyte_q;
   assign done       = (st == S_DONE);
   assign done_err   = err_q;
   assign done_nacks = nacks_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_RECOV;
         wait_q  <= 1'b0;
         op_q    <= OP_PROBE;
         chip_q  <= '0;
         addr_q  <= '0;
         alen_q  <= '0;
         len_q   <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         nacks_q <= '0;
         err_q   <= 1'b0;
         rbyte_q <= '0;
      end else begin
         if (cmd_valid && cmd_ready) wait_q <= 1'b1;
         if (wait_q && rsp_valid) begin
            wait_q <= 1'b0;
            unique case (st)
               S_RECOV:  st <= S_IDLE;
               S_START:  st <= (op_q == OP_READ && alen_q == '0 && len_q != '0) ? S_CHIPR : S_CHIPW;
               S_CHIPW: begin
                  if (rsp_nack) begin err_q <= 1'b1; st <= S_STOP; end
                  else if (op_q == OP_PROBE || op_q == OP_RSVD) st <= S_STOP;
                  else if (alen_q != '0) begin idx_q <= '0; st <= S_ADDR; end
                  else st <= after_addr;
               end
               S_ADDR: begin
                  if (rsp_nack) begin err_q <= 1'b1; st <= S_STOP; end
                  else if (idx_q == alen_q - ALW'(1)) st <= after_addr;
                  else idx_q <= idx_q + ALW'(1);
               end
               S_TURN:   st <= S_START2;
               S_START2: st <= S_CHIPR;
               S_CHIPR: begin
                  if (rsp_nack) begin err_q <= 1'b1; st <= S_STOP; end
                  else begin cnt_q <= '0; st <= S_RDATA; end
               end
               S_WDATA: begin
                  if (rsp_nack) nacks_q <= nacks_q + LW'(1);
                  if (last_byte) st <= S_STOP;
                  else cnt_q <= cnt_q + LW'(1);
               end
               S_RDATA: begin rbyte_q <= rsp_byte; st <= S_RDOUT; end
               S_STOP:  st <= S_DONE;
               default: ;
            endcase
         end
         unique case (st)
            S_IDLE: begin
               if (init_req) st <= S_RECOV;
               else if (req_valid) begin
                  op_q    <= op_e'(req_op);
                  chip_q  <= chip_in;
                  addr_q  <= req_addr;
                  alen_q  <= req_alen;
                  len_q   <= req_len;
                  cnt_q   <= '0;
                  nacks_q <= '0;
                  err_q   <= 1'b0;
                  st      <= S_START;
               end
            end
            S_RDOUT: if (rd_ready) begin
               if (last_byte) st <= S_STOP;
               else begin cnt_q <= cnt_q + LW'(1); st <= S_RDATA; end
            end
            S_DONE:  st <= S_IDLE;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq #(
   parameter int         ABYTES_MAX = 4,
   parameter int         LEN_MAX    = 256,
   parameter bit         REP_START  = 1'b1,
   parameter logic [6:0] OVF_MASK   = 7'h00,
   localparam int        AW         = 8 * ABYTES_MAX,
   localparam int        ALW        = $clog2(ABYTES_MAX + 1),
   localparam int        LW         = $clog2(LEN_MAX + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           init_req,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [1:0]     req_op,
   input  logic [6:0]     req_chip,
   input  logic [AW-1:0]  req_addr,
   input  logic [ALW-1:0] req_alen,
   input  logic [LW-1:0]  req_len,
   input  logic           wr_valid,
   output logic           wr_ready,
   input  logic [7:0]     wr_data,
   output logic           rd_valid,
   input  logic           rd_ready,
   output logic [7:0]     rd_data,
   output logic           cmd_valid,
   input  logic           cmd_ready,
   output logic [2:0]     cmd_code,
   output logic [7:0]     cmd_byte,
   output logic           cmd_nack,
   input  logic           rsp_valid,
   input  logic           rsp_nack,
   input  logic [7:0]     rsp_byte,
   output logic           done,
   output logic           done_err,
   output logic [LW-1:0]  done_nacks
);
   generate
      if (ABYTES_MAX < 1 || ABYTES_MAX > 4) begin : g_bad_abytes
         $error("ABYTES_MAX must lie in 1..4");
      end
      if (LEN_MAX < 1) begin : g_bad_len
         $error("LEN_MAX must be at least 1");
      end
   endgenerate

   logic [6:0]     chip_f;
   logic [AW-1:0]  addr_q;
   logic [ALW-1:0] alen_q;
   logic [ALW-1:0] idx_q;
   logic [7:0]     abyte;

   i2c_xact_seq_chipfold #(.AW(AW), .ALW(ALW), .OVF_MASK(OVF_MASK)) u_fold (
      .chip(req_chip), .addr(req_addr), .alen(req_alen), .chip_out(chip_f)
   );

   i2c_xact_seq_bytepick #(.ABYTES_MAX(ABYTES_MAX), .AW(AW), .ALW(ALW)) u_pick (
      .addr(addr_q), .alen(alen_q), .idx(idx_q), .abyte(abyte)
   );

   i2c_xact_seq_fsm #(.AW(AW), .ALW(ALW), .LW(LW), .REP_START(REP_START)) u_fsm (
      .clk(clk), .rst_n(rst_n), .init_req(init_req),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .chip_in(chip_f), .req_addr(req_addr), .req_alen(req_alen), .req_len(req_len),
      .addr_q(addr_q), .alen_q(alen_q), .idx_q(idx_q), .abyte(abyte),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
      .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
      .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte),
      .done(done), .done_err(done_err), .done_nacks(done_nacks)
   );
endmodule

// File: rtl/i2c_xact_seq_chk.sv
module i2c_xact_seq_chk
   import i2c_xact_seq_pkg::*;
#(
   parameter int LW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic [7:0]    rd_data,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [2:0]    cmd_code,
   input logic [7:0]    cmd_byte,
   input logic          done,
   input logic [LW-1:0] done_nacks
);
   AST_RECOVER_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code == CMD_RECOVER |-> !req_ready);                // R1

   AST_WRITE_STREAM_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready |-> cmd_valid && cmd_code == CMD_WRITE);         // R3

   AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));              // R8

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_byte)); // R11

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                      // R11

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && !done);                      // R11

   AST_NACKS_STABLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done && !$past(req_ready) |-> $stable(done_nacks));                   // R5
endmodule

bind i2c_xact_seq i2c_xact_seq_chk #(.LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .wr_valid(wr_valid), .wr_ready(wr_ready),
   .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
   .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
   .cmd_byte(cmd_byte), .done(done), .done_nacks(done_nacks)
);

// File: tb/i2c_xact_seq_tb.sv
module i2c_xact_seq_tb_engine (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [15:0]     nmask,
   input  logic            cmd_valid,
   input  logic [2:0]      cmd_code,
   input  logic [7:0]      cmd_byte,
   input  logic            cmd_nack,
   output logic            cmd_ready,
   output logic            rsp_valid,
   output logic            rsp_nack,
   output logic [7:0]      rsp_byte,
   output logic [64*12-1:0] log_v,
   output logic [6:0]      log_n
);
   logic [3:0] wk;
   logic [7:0] rk;
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cmd_ready <= 1'b0; rsp_valid <= 1'b0; rsp_nack <= 1'b0; rsp_byte <= 8'h00;
         log_v <= '0; log_n <= '0; wk <= '0; rk <= '0;
      end else begin
         cmd_ready <= ~cmd_ready;
         rsp_valid <= 1'b0;
         if (cmd_valid && cmd_ready) begin
            if (log_n < 7'd64) begin
               log_v[log_n*12 +: 12] <= {cmd_code, cmd_byte, cmd_nack};
               log_n <= log_n + 7'd1;
            end
            rsp_valid <= 1'b1;
            rsp_nack  <= (cmd_code == 3'd3) ? nmask[wk] : 1'b0;
            if (cmd_code == 3'd3) wk <= wk + 4'd1;
            if (cmd_code == 3'd4) begin rsp_byte <= 8'hA0 + rk; rk <= rk + 8'd1; end
         end
      end
   end
endmodule

module i2c_xact_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;
   // op, chip, addr, alen, len, nack mask (by write-command position)
   localparam int V_OP  [NV] = '{0, 0, 1, 1, 1, 2, 2, 1, 1, 2, 2};
   localparam int V_CHIP[NV] = '{'h50,'h51,'h50,'h22,'h30,'h40,'h41,'h50,'h33,'h34,'h44};
   localparam int V_ADDR[NV] = '{0, 0, 'h1234, 'hAB, 'h5678, 'h0102, 0, 'h2A5, 'h10, 0, 0};
   localparam int V_ALEN[NV] = '{0, 0, 2, 1, 2, 2, 0, 1, 1, 0, 0};
   localparam int V_LEN [NV] = '{0, 0, 3, 4, 2, 3, 2, 1, 0, 0, 2};
   localparam int V_NM  [NV] = '{0, 1, 0, 'b10100, 'b100, 0, 0, 0, 0, 0, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_req = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [6:0]  req_chip = '0;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_alen = '0;
   logic [8:0]  req_len = '0;
   logic        clr = 1'b0;
   logic [15:0] nmask = '0;

   logic              l_ready [2];
   logic              l_seen  [2];
   logic              l_err   [2];
   logic [8:0]        l_nk    [2];
   logic [64*12-1:0]  l_log   [2];
   logic [6:0]        l_logn  [2];
   logic [127:0]      l_rbuf  [2];
   logic [4:0]        l_rcnt  [2];

   int checks = 0;
   int errors = 0;
   int exp_e [64];
   int exp_n, exp_err, exp_nk;

   always #(CLK_PERIOD/2) clk = ~clk;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         logic wr_ready, rd_valid, cmd_valid, cmd_nack, cmd_ready;
         logic rsp_valid, rsp_nack, done, done_err, rdr;
         logic [7:0] rd_data, cmd_byte, rsp_byte, wcnt;
         logic [2:0] cmd_code;
         logic [8:0] done_nacks;
         logic [4:0] rcnt;
         logic [127:0] rbuf;
         logic seen, errc;
         logic [8:0] nkc;

         i2c_xact_seq #(.REP_START(g == 0 ? 1'b1 : 1'b0), .OVF_MASK(7'h03)) u_dut (
            .clk(clk), .rst_n(rst_n), .init_req(init_req),
            .req_valid(req_valid), .req_ready(l_ready[g]), .req_op(req_op),
            .req_chip(req_chip), .req_addr(req_addr), .req_alen(req_alen), .req_len(req_len),
            .wr_valid(1'b1), .wr_ready(wr_ready), .wr_data(8'h50 + wcnt),
            .rd_valid(rd_valid), .rd_ready(rdr), .rd_data(rd_data),
            .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
            .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
            .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_byte(rsp_byte),
            .done(done), .done_err(done_err), .done_nacks(done_nacks)
         );

         i2c_xact_seq_tb_engine u_model (
            .clk(clk), .rst_n(rst_n), .clr(clr), .nmask(nmask),
            .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_byte(cmd_byte),
            .cmd_nack(cmd_nack), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
            .rsp_nack(rsp_nack), .rsp_byte(rsp_byte), .log_v(l_log[g]), .log_n(l_logn[g])
         );

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               wcnt <= '0; rcnt <= '0; rbuf <= '0; seen <= 1'b0; errc <= 1'b0; nkc <= '0;
               rdr <= 1'b0;
            end else begin
               rdr <= ~rdr;
               if (wr_ready) wcnt <= wcnt + 8'd1;
               if (rd_valid && rdr && rcnt < 5'd16) begin
                  rbuf[rcnt*8 +: 8] <= rd_data;
                  rcnt <= rcnt + 5'd1;
               end
               if (done) begin seen <= 1'b1; errc <= done_err; nkc <= done_nacks; end
            end
         end
         assign l_seen[g] = seen;
         assign l_err[g]  = errc;
         assign l_nk[g]   = nkc;
         assign l_rbuf[g] = rbuf;
         assign l_rcnt[g] = rcnt;
      end
   endgenerate

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input int code, input int b, input int n);
      exp_e[exp_n] = (code << 9) | (b << 1) | n;
      exp_n++;
   endtask

   // expected command list from the requirements; codes 0 RECOVER 1 START 2 STOP 3 WRITE 4 READ
   task automatic build_exp(input int rs, input int op, input int chip, input int addr,
                            input int alen, input int len, input int nm);
      int wk = 0;
      int chipf;
      longint ext = longint'(addr);
      exp_n = 0; exp_err = 0; exp_nk = 0;
      chipf = (chip | int'((ext >> (8*alen)) & 3)) & 'h7f;          // R9
      push(1, 0, 0);
      if (!(op == 2 && alen == 0 && len > 0)) begin
         push(3, chipf << 1, 0);
         if ((nm >> wk++) & 1) begin push(2, 0, 0); exp_err = 1; return; end  // R4
         if (op == 0 || op == 3) begin push(2, 0, 0); return; end           // R2
         for (int i = 0; i < alen; i++) begin
            push(3, (addr >> (8*(alen-1-i))) & 255, 0);                    // R3
            if ((nm >> wk++) & 1) begin push(2, 0, 0); exp_err = 1; return; end
         end
         if (len == 0) begin push(2, 0, 0); return; end                      // R10
         if (op == 1) begin
            for (int i = 0; i < len; i++) begin
               push(3, ('h50 + i) & 255, 0);
               if ((nm >> wk++) & 1) exp_nk++;                               // R5
            end
            push(2, 0, 0);
            return;
         end
         if (rs == 0) push(2, 0, 0);                                         // R6
         push(1, 0, 0);
      end
      push(3, (chipf << 1) | 1, 0);                                          // R7
      if ((nm >> wk++) & 1) begin push(2, 0, 0); exp_err = 1; return; end
      for (int i = 0; i < len; i++) push(4, 0, (i == len-1) ? 1 : 0);       // R8
      push(2, 0, 0);
   endtask

   task automatic do_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic wait_both();
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (l_seen[0] && l_seen[1]) return;
      end
   endtask

   task automatic run_vec(input int v, input string tag);
      do_clr();
      nmask = V_NM[v][15:0];
      req_op = V_OP[v][1:0]; req_chip = V_CHIP[v][6:0]; req_addr = V_ADDR[v];
      req_alen = V_ALEN[v][2:0]; req_len = V_LEN[v][8:0];
      req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
      chk(!l_ready[0] && !l_ready[1], "R11", "ready low while busy", l_ready[0], 0);
      wait_both();
      for (int ln = 0; ln < 2; ln++) begin
         int bad = -1;
         build_exp(ln == 0 ? 1 : 0, V_OP[v], V_CHIP[v], V_ADDR[v], V_ALEN[v], V_LEN[v], V_NM[v]);
         chk(l_seen[ln], tag, "done seen", l_seen[ln], 1);
         chk(int'(l_logn[ln]) == exp_n, tag, "command count", l_logn[ln], exp_n);
         for (int k = 0; k < exp_n && k < 64; k++)
            if (bad < 0 && int'(l_log[ln][k*12 +: 12]) != exp_e[k]) bad = k;
         chk(bad < 0, tag, "command list", bad < 0 ? 0 : int'(l_log[ln][bad*12 +: 12]),
             bad < 0 ? 0 : exp_e[bad]);
         chk(int'(l_err[ln]) == exp_err, tag, "error flag", l_err[ln], exp_err);
         chk(int'(l_nk[ln]) == exp_nk, tag, "nack count", l_nk[ln], exp_nk);
         if (V_OP[v] == 2 && exp_err == 0) begin
            chk(int'(l_rcnt[ln]) == V_LEN[v], "R8", "read byte count", l_rcnt[ln], V_LEN[v]);
            for (int i = 0; i < V_LEN[v]; i++)
               chk(int'(l_rbuf[ln][i*8 +: 8]) == 'hA0 + i, "R8", "read byte",
                   l_rbuf[ln][i*8 +: 8], 'hA0 + i);
         end
      end
   endtask

   function automatic string tag_of(input int v);
      case (v)
         0: return "R2";   1: return "R4";   2: return "R3";  3: return "R5";
         4: return "R4";   5: return "R6";   6: return "R7";  7: return "R9";
         8: return "R10";  9: return "R10"; default: return "R4";
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!l_ready[0] && !l_ready[1], "R1", "ready low during recovery", l_ready[0], 0);
      for (int c = 0; c < 100 && !(l_ready[0] && l_ready[1]); c++) @(negedge clk);
      for (int ln = 0; ln < 2; ln++) begin
         chk(l_logn[ln] == 7'd1, "R1", "one command after reset", l_logn[ln], 1);
         chk(l_log[ln][11:9] == 3'd0, "R1", "recovery code", l_log[ln][11:9], 0);
      end

      for (int v = 0; v < NV; v++) run_vec(v, tag_of(v));

      // R1: init request while idle
      do_clr();
      init_req = 1'b1;
      @(negedge clk); init_req = 1'b0;
      chk(!l_ready[0], "R1", "ready low after init", l_ready[0], 0);
      for (int c = 0; c < 100 && !(l_ready[0] && l_ready[1]); c++) @(negedge clk);
      for (int ln = 0; ln < 2; ln++) begin
         chk(l_logn[ln] == 7'd1, "R1", "one command after init", l_logn[ln], 1);
         chk(l_log[ln][11:9] == 3'd0, "R1", "init recovery code", l_log[ln][11:9], 0);
      end

      // R2 with reserved op 3 behaving as a probe
      begin
         do_clr();
         nmask = 16'h0; req_op = 2'd3; req_chip = 7'h12; req_addr = '0; req_alen = 3'd0; req_len = 9'd5;
         req_valid = 1'b1;
         @(negedge clk); req_valid = 1'b0;
         wait_both();
         chk(l_logn[1] == 7'd3, "R2", "op3 probe length", l_logn[1], 3);
         chk(l_log[1][12 +: 12] == {3'd3, 8'h24, 1'b0}, "R2", "op3 address byte",
             l_log[1][12 +: 12], {3'd3, 8'h24, 1'b0});
         chk(!l_err[1], "R2", "op3 probe present", l_err[1], 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule